// File: doc/BRIEF.md
# Keyed windowed watchdog timer

This block is a watchdog for a bus-attached subsystem. A 32-bit up-counter runs on the bus clock. When it reaches a programmable time-out limit, the block treats it as a fault. To keep the system alive, software writes a two-word refresh key to a service address, which sends the counter back to zero. A second two-word key unlocks the configuration for a short, bounded period. A mistyped key, a key that arrives too late, or an early refresh in windowed mode is a fault as well.

A fault either requests a system reset at once, or raises an interrupt first and requests the reset a fixed number of cycles later. In the second case a valid refresh in that interval cancels the reset. Four mode inputs can pause the counter, each under its own enable bit. An 8-bit saturating tally records the resets the block has issued and is visible on an output.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, irq, sys_rst_req and rst_count are 0. The block is enabled with windowed mode and interrupt-first off, the mode enables are off, the time-out limit is all ones and the window start is 0. An invalid service write right after reset therefore causes a reset request.
- R2: Address 0 is the service register and its bits [15:0] are the key. Writing 0xC520 and then 0xD928, with the second write at most KEY_GAP (20) cycles after the first, opens configuration access.
- R3: Writing 0xA602 and then 0xB480 to the service register, with the second write at most KEY_GAP cycles after the first, reloads the counter to zero.
- R4: Each of the following is a fault and returns the key sequencer to idle: a service write that is not the expected next key word, or a first key word followed by no second word within KEY_GAP cycles.
- R5: Writes to the control (address 1), limit (address 2) and window start (address 3) registers take effect only in the UNLOCK_WIN (256) cycles after a valid unlock. All other such writes are ignored.
- R6: When the counter value is greater than or equal to the limit register, a time-out fault occurs.
- R7: Control bit 1 enables windowed mode. With this bit set, a refresh pair that completes while the counter is below the window start register is a fault and does not reload the counter.
- R8: Control bit 2 selects interrupt-first. With this bit clear, a fault drives sys_rst_req high for one cycle in the cycle after the fault, and the counter restarts from zero.
- R9: With control bit 2 set, a fault raises irq in the next cycle. sys_rst_req follows IRQ_DELAY (128) cycles after irq rises, and irq falls at the same time. A valid refresh in that interval drops irq and cancels the reset.
- R10: Control bits 3, 4, 5 and 6 let the counter run while mode_wait, mode_stop, mode_standby and mode_debug are high, respectively. When a mode input is high and its bit is clear, the counter holds.
- R11: Control bit 0 is the global enable. When it is clear the counter holds and no fault is raised, but the unlock and refresh keys still take effect.
- R12: rst_count increments on each reset request and saturates at 255. Any write to address 4 clears it, and a clear takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also the counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 service, 1 control, 2 limit, 3 window start, 4 reset-tally clear |
| wr_data | input | 32 | Write data |
| mode_wait | input | 1 | Wait mode active |
| mode_stop | input | 1 | Stop mode active |
| mode_standby | input | 1 | Standby mode active |
| mode_debug | input | 1 | Debug mode active |
| irq | output | 1 | Interrupt raised ahead of a pending reset |
| sys_rst_req | output | 1 | One-cycle system reset request |
| rst_count | output | 8 | Saturating tally of issued resets |

## Verification
The bench builds the block with its default parameters. KEY_GAP = 20, UNLOCK_WIN = 256 and IRQ_DELAY = 128 are all short enough to reach both sides of every boundary: a key gap of 20 against 21 cycles, a configuration write on unlock cycle 256 against 257, and the full 128-cycle interrupt lead. The 32-bit counter stays at full width. Software programs the limit down to small values, so time-outs, window faults and tally saturation all happen within a few thousand cycles.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_UNL, SEQ_REF} seq_t;

  localparam logic [15:0] KEY_UNL_A = 16'hC520;
  localparam logic [15:0] KEY_UNL_B = 16'hD928;
  localparam logic [15:0] KEY_REF_A = 16'hA602;
  localparam logic [15:0] KEY_REF_B = 16'hB480;

  localparam logic [2:0] ADR_SVC  = 3'd0;
  localparam logic [2:0] ADR_CTRL = 3'd1;
  localparam logic [2:0] ADR_LIM  = 3'd2;
  localparam logic [2:0] ADR_WIN  = 3'd3;
  localparam logic [2:0] ADR_RCLR = 3'd4;

  typedef struct packed {
    logic dbg_en;
    logic sby_en;
    logic stp_en;
    logic wt_en;
    logic irq_first;
    logic win_en;
    logic enable;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = 7'b0000001;
endpackage

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
  import wdog_pkg::*;
#(
  parameter int KEY_GAP = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        svc_wr,
  input  logic [15:0] svc_key,
  input  logic        abort,
  output logic        unlock_o,
  output logic        refresh_o,
  output logic        fault_o
);
  localparam int GW = $clog2(KEY_GAP + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(KEY_GAP - 1);

  seq_t          state_q, state_d;
  logic [GW-1:0] gap_q, gap_d;

  always_comb begin
    state_d   = state_q;
    gap_d     = gap_q;
    unlock_o  = 1'b0;
    refresh_o = 1'b0;
    fault_o   = 1'b0;
    if (state_q != SEQ_IDLE && !svc_wr) begin
      if (gap_q == GAP_LAST) begin
        fault_o = 1'b1;
        state_d = SEQ_IDLE;
      end else begin
        gap_d = gap_q + 1'b1;
      end
    end
    if (svc_wr) begin
      case (state_q)
        SEQ_IDLE: begin
          gap_d = '0;
          if (svc_key == KEY_UNL_A)      state_d = SEQ_UNL;
          else if (svc_key == KEY_REF_A) state_d = SEQ_REF;
          else                           fault_o = 1'b1;
        end
        SEQ_UNL: begin
          state_d = SEQ_IDLE;
          if (svc_key == KEY_UNL_B) unlock_o = 1'b1;
          else                      fault_o  = 1'b1;
        end
        SEQ_REF: begin
          state_d = SEQ_IDLE;
          if (svc_key == KEY_REF_B) refresh_o = 1'b1;
          else                      fault_o   = 1'b1;
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
    if (abort) begin
      state_d = SEQ_IDLE;
      gap_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      gap_q   <= gap_d;
    end
  end

  assert_gap_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= GAP_LAST);
  assert_idle_after_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> state_q == SEQ_IDLE);
  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({unlock_o, refresh_o, fault_o}));
endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import wdog_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int UNLOCK_WIN = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unlock,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] limit_o,
  output logic [CNT_W-1:0] win_o
);
  localparam int UW = $clog2(UNLOCK_WIN + 1);

  logic [UW-1:0]    unl_q, unl_d;
  logic             open;
  logic             ctrl_we, lim_we, win_we;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] lim_q, win_q;

  assign open    = (unl_q != '0);
  assign ctrl_we = wr_en && open && (wr_addr == ADR_CTRL);
  assign lim_we  = wr_en && open && (wr_addr == ADR_LIM);
  assign win_we  = wr_en && open && (wr_addr == ADR_WIN);

  always_comb begin
    if (unlock)    unl_d = UW'(UNLOCK_WIN);
    else if (open) unl_d = unl_q - 1'b1;
    else           unl_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unl_q <= '0;
    else        unl_q <= unl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RST;
    else if (ctrl_we) ctrl_q <= ctrl_t'(wr_data[6:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lim_q <= '1;
    else if (lim_we) lim_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= '0;
    else if (win_we) win_q <= wr_data;
  end

  assign ctrl_o  = ctrl_q;
  assign limit_o = lim_q;
  assign win_o   = win_q;

  assert_locked_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !open |=> $stable(lim_q));
  assert_locked_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !open |=> $stable(ctrl_q));
  assert_window_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |=> unl_q == UW'(UNLOCK_WIN));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = run || restart;

  always_comb begin
    if (restart) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0);
endmodule

// File: rtl/wdog_fault.sv
module wdog_fault #(
  parameter int IRQ_DELAY = 128,
  parameter int RC_W      = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fault_in,
  input  logic            irq_first,
  input  logic            cancel,
  input  logic            rc_clr,
  output logic            issue_o,
  output logic            irq_o,
  output logic            rst_req_o,
  output logic [RC_W-1:0] rc_o
);
  localparam int DW = $clog2(IRQ_DELAY + 1);
  localparam logic [RC_W-1:0] RC_MAX = '1;

  logic            irq_q, irq_d;
  logic [DW-1:0]   dly_q, dly_d;
  logic            rst_q;
  logic [RC_W-1:0] rc_q, rc_d;
  logic            rc_en;

  always_comb begin
    issue_o = 1'b0;
    irq_d   = irq_q;
    dly_d   = dly_q;
    if (irq_q) begin
      if (cancel) begin
        irq_d = 1'b0;
      end else if (dly_q == '0) begin
        issue_o = 1'b1;
        irq_d   = 1'b0;
      end else begin
        dly_d = dly_q - 1'b1;
      end
    end else if (fault_in) begin
      if (irq_first) begin
        irq_d = 1'b1;
        dly_d = DW'(IRQ_DELAY - 1);
      end else begin
        issue_o = 1'b1;
      end
    end
  end

  assign rc_en = rc_clr || (issue_o && rc_q != RC_MAX);
  assign rc_d  = rc_clr ? '0 : rc_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      dly_q <= '0;
      rst_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      dly_q <= dly_d;
      rst_q <= issue_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rc_q <= '0;
    else if (rc_en) rc_q <= rc_d;
  end

  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;
  assign rc_o      = rc_q;

  assert_irq_then_rst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && dly_q == '0 && !cancel) |=> (rst_q && !irq_q));
  assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && cancel) |=> (!irq_q && !rst_q));
  assert_tally_sat_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_q == RC_MAX && !rc_clr) |=> rc_q == RC_MAX);
  assert_tally_clr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rc_clr |=> rc_q == '0);
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int KEY_GAP    = 20,
  parameter int UNLOCK_WIN = 256,
  parameter int IRQ_DELAY  = 128,
  parameter int RC_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             mode_wait,
  input  logic             mode_stop,
  input  logic             mode_standby,
  input  logic             mode_debug,
  output logic             irq,
  output logic             sys_rst_req,
  output logic [RC_W-1:0]  rst_count
);
  logic             svc_wr, seq_unlock, seq_refresh, seq_fault;
  logic             issue, early, refresh_good, timeout, run, restart, fault_any;
  logic             mode_block;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] limit, win_start, count;

  assign svc_wr = wr_en && (wr_addr == ADR_SVC);

  wdog_keyseq #(.KEY_GAP(KEY_GAP)) u_seq (
    .clk(clk), .rst_n(rst_n), .svc_wr(svc_wr), .svc_key(wr_data[15:0]),
    .abort(issue), .unlock_o(seq_unlock), .refresh_o(seq_refresh), .fault_o(seq_fault)
  );

  wdog_cfg #(.CNT_W(CNT_W), .UNLOCK_WIN(UNLOCK_WIN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .unlock(seq_unlock), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_o(ctrl), .limit_o(limit), .win_o(win_start)
  );

  assign mode_block = (mode_wait && !ctrl.wt_en) || (mode_stop && !ctrl.stp_en) ||
                      (mode_standby && !ctrl.sby_en) || (mode_debug && !ctrl.dbg_en);
  assign run          = ctrl.enable && !mode_block;
  assign early        = ctrl.win_en && (count < win_start);
  assign refresh_good = seq_refresh && !early;
  assign timeout      = count >= limit;
  assign fault_any    = ctrl.enable && (seq_fault || (seq_refresh && early) || timeout);
  assign restart      = issue || refresh_good;

  wdog_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart), .count_o(count)
  );

  wdog_fault #(.IRQ_DELAY(IRQ_DELAY), .RC_W(RC_W)) u_flt (
    .clk(clk), .rst_n(rst_n), .fault_in(fault_any), .irq_first(ctrl.irq_first),
    .cancel(refresh_good), .rc_clr(wr_en && (wr_addr == ADR_RCLR)),
    .issue_o(issue), .irq_o(irq), .rst_req_o(sys_rst_req), .rc_o(rst_count)
  );

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(count));
  assert_quiet_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.enable && !irq) |=> !sys_rst_req);
  assert_early_no_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_refresh && early && !irq) |=> (sys_rst_req || irq));
endmodule

// File: tb/wdog_keyed_test.sv
module wdog_keyed_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic        mode_wait, mode_stop, mode_standby, mode_debug;
  logic        irq, sys_rst_req;
  logic [7:0]  rst_count;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int base;

  always #10 clk = ~clk;

  wdog_keyed uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_wait(mode_wait), .mode_stop(mode_stop), .mode_standby(mode_standby),
    .mode_debug(mode_debug), .irq(irq), .sys_rst_req(sys_rst_req), .rst_count(rst_count)
  );

  // {first word, second word, gap in cycles, expected reset-tally increase}
  localparam logic [47:0] VEC [8] = '{
    {16'hA602, 16'hB480, 8'd1,  8'd0},
    {16'hC520, 16'hD928, 8'd1,  8'd0},
    {16'hA602, 16'hB480, 8'd20, 8'd0},
    {16'hA602, 16'hB480, 8'd21, 8'd2},
    {16'hC520, 16'hD928, 8'd20, 8'd0},
    {16'hC520, 16'hD928, 8'd21, 8'd2},
    {16'hA602, 16'hC520, 8'd1,  8'd1},
    {16'h1234, 16'hA602, 8'd2,  8'd2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 3'd7; wr_data = '0;
  endtask

  task automatic unlock();
    wr(3'd0, 32'hC520); wr(3'd0, 32'hD928);
  endtask

  task automatic refresh();
    wr(3'd0, 32'hA602); wr(3'd0, 32'hB480);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 3'd7; wr_data = '0;
    mode_wait = 1'b0; mode_stop = 1'b0; mode_standby = 1'b0; mode_debug = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq == 1'b0, "R1 irq", int'(irq), 0);
    chk(sys_rst_req == 1'b0, "R1 sys_rst_req", int'(sys_rst_req), 0);
    chk(rst_count == 8'd0, "R1 rst_count", int'(rst_count), 0);
    // enabled out of reset: a stray key word causes a reset
    wr(3'd0, 32'h1234);
    repeat (2) @(negedge clk);
    chk(rst_count == 8'd1, "R1 enabled at reset", int'(rst_count), 1);
    wr(3'd4, 32'h0);
    chk(rst_count == 8'd0, "R12 clear", int'(rst_count), 0);

    unlock(); wr(3'd2, 32'd5000); refresh();
    for (int i = 0; i < 8; i++) begin
      refresh();
      base = int'(rst_count);
      wr(3'd0, {16'h0, VEC[i][47:32]});
      repeat (int'(VEC[i][15:8]) - 1) @(negedge clk);
      wr(3'd0, {16'h0, VEC[i][31:16]});
      repeat (30) @(negedge clk);
      chk(int'(rst_count) - base == int'(VEC[i][7:0]), "R2,R3,R4 key vector",
          int'(rst_count) - base, int'(VEC[i][7:0]));
    end

    // R6 and R8: time-out at limit 50, reset pulse one cycle later
    unlock(); wr(3'd2, 32'd50); refresh();
    repeat (50) @(negedge clk);
    chk(sys_rst_req == 1'b0, "R6 before limit", int'(sys_rst_req), 0);
    @(negedge clk);
    chk(sys_rst_req == 1'b1, "R6 time-out reset", int'(sys_rst_req), 1);
    @(negedge clk);
    chk(sys_rst_req == 1'b0, "R8 one-cycle pulse", int'(sys_rst_req), 0);

    // R9: interrupt first, reset 128 cycles later
    unlock(); wr(3'd1, 32'h05); refresh();
    repeat (51) @(negedge clk);
    chk(irq == 1'b1, "R9 irq raised", int'(irq), 1);
    repeat (127) @(negedge clk);
    chk(sys_rst_req == 1'b0 && irq == 1'b1, "R9 still waiting", int'(sys_rst_req), 0);
    @(negedge clk);
    chk(sys_rst_req == 1'b1 && irq == 1'b0, "R9 reset after delay", int'(sys_rst_req), 1);
    refresh();
    repeat (60) @(negedge clk);
    base = int'(rst_count);
    refresh();
    chk(irq == 1'b0, "R9 refresh drops irq", int'(irq), 0);
    repeat (150) @(negedge clk);
    chk(int'(rst_count) == base, "R9 refresh cancels reset", int'(rst_count), base);
    refresh(); unlock(); wr(3'd1, 32'h01); wr(3'd2, 32'd5000); refresh();

    // R7: windowed mode
    unlock(); wr(3'd3, 32'd30); wr(3'd1, 32'h03);
    base = int'(rst_count);
    refresh();
    @(negedge clk);
    chk(int'(rst_count) == base + 1, "R7 early refresh fault", int'(rst_count), base + 1);
    repeat (40) @(negedge clk);
    base = int'(rst_count);
    refresh();
    repeat (3) @(negedge clk);
    chk(int'(rst_count) == base, "R7 in-window refresh", int'(rst_count), base);
    unlock(); wr(3'd1, 32'h01); refresh();

    // R5: last cycle of the unlock window accepted, next one ignored
    unlock();
    repeat (255) @(negedge clk);
    wr(3'd2, 32'd40);
    refresh();
    base = int'(rst_count);
    repeat (50) @(negedge clk);
    chk(int'(rst_count) == base + 1, "R5 write on cycle 256", int'(rst_count), base + 1);
    unlock();
    repeat (256) @(negedge clk);
    wr(3'd2, 32'd5000);
    refresh();
    base = int'(rst_count);
    repeat (50) @(negedge clk);
    chk(int'(rst_count) == base + 1, "R5 write on cycle 257 ignored", int'(rst_count), base + 1);

    // R10: mode gating (limit still 40)
    refresh();
    mode_wait = 1'b1;
    base = int'(rst_count);
    repeat (100) @(negedge clk);
    chk(int'(rst_count) == base, "R10 wait holds counter", int'(rst_count), base);
    mode_wait = 1'b0;
    repeat (50) @(negedge clk);
    chk(int'(rst_count) == base + 1, "R10 resumes", int'(rst_count), base + 1);
    unlock(); wr(3'd1, 32'h41); refresh();
    mode_debug = 1'b1;
    base = int'(rst_count);
    repeat (50) @(negedge clk);
    chk(int'(rst_count) == base + 1, "R10 debug enable runs", int'(rst_count), base + 1);
    mode_debug = 1'b0;

    // R11: global enable off
    refresh(); unlock(); wr(3'd1, 32'h00);
    base = int'(rst_count);
    wr(3'd0, 32'h1234);
    repeat (100) @(negedge clk);
    chk(int'(rst_count) == base, "R11 disabled is quiet", int'(rst_count), base);
    refresh(); unlock(); wr(3'd1, 32'h01);

    // R12: saturation and clear priority
    wr(3'd2, 32'd1); refresh();
    repeat (1000) @(negedge clk);
    chk(rst_count == 8'd255, "R12 saturates", int'(rst_count), 255);
    wr(3'd4, 32'h0);
    chk(rst_count == 8'd0, "R12 clear while busy", int'(rst_count), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule